// File: doc/BRIEF.md
# AGC Gain Stepper with Attack and Release Ticks

This block is the digital control loop of an automatic gain controller. An upstream rectifier and averager deliver one mean signal level per completed sample set, together with a one-cycle strobe. On each strobe the block compares the level against a configured band. It then records a pending compress request or a pending expand request, or clears both. It also records the absolute distance between the level and the configured nominal level.

Between strobes, a gain index walks through a gain lookup table, one entry at a time. Compression steps downward on a fast attack tick. Expansion steps upward on a release tick that runs at half that rate. The index saturates at both ends of the table. The gain code sent to the external programmable amplifier is the entry at the current index. Several transfer curves are built in, and an external select input picks one of them. An internal base-tick generator divides the clock down to the attack period, which is nominally 1 ms.

Top module: `agc_step_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the index equals UNITY_IDX (default 8), both requests are clear, and the gain output shows the entry at that index.
- R2: An attack tick occurs once every TICK_DIV clock cycles. While compression stays enabled, consecutive downward index steps are exactly TICK_DIV cycles apart.
- R3: A release tick occurs on every second attack tick, in the same cycle as that attack tick. While expansion stays enabled, consecutive upward index steps are exactly 2*TICK_DIV cycles apart.
- R4: On a set strobe, a level strictly above hi_thr_i requests compression. A level strictly below lo_thr_i requests expansion. A level in [lo_thr_i, hi_thr_i] clears both requests. At most one request is ever pending.
- R5: Requests and delta change only on a set strobe. Changing avg_i without a strobe leaves the index stepping behaviour unchanged.
- R6: On an attack tick with compression pending and a nonzero delta, the index drops by one, but never below 0.
- R7: On a release tick with expansion pending and a nonzero delta, the index rises by one, but never above 2**IDX_W-1 (default 15).
- R8: A delta of zero (latched level equal to nom_i) blocks all steps, even when a request is pending.
- R9: The index changes by at most one position per clock cycle, and only in the cycle after a matching tick.
- R10: The gain output is combinational from the index and tbl_sel_i. Even-numbered tables give code i*16+8, and odd-numbered tables give i*i+i (defaults GAIN_W=8, IDX_W=4). A select value beyond the last table picks the last table.
- R11: With no request pending, ticks leave the index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_valid_i | input | 1 | One-cycle strobe marking a completed sample-set average |
| avg_i | input | LVL_W | Averaged rectified level |
| lo_thr_i | input | LVL_W | Lower edge of the nominal band |
| hi_thr_i | input | LVL_W | Upper edge of the nominal band |
| nom_i | input | LVL_W | Nominal level used for the delta |
| tbl_sel_i | input | SEL_W | Gain table select |
| gain_o | output | GAIN_W | Gain code from the selected table |
| idx_o | output | IDX_W | Current table index |

## Verification
The assertions assume that lo_thr_i does not exceed hi_thr_i and that thresholds and nom_i are held steady while a sample set is judged. The stimulus sets them only between strobes and keeps the band ordered. The assertions also assume set_valid_i is a single-cycle pulse. The bench always raises it for exactly one cycle, with many idle cycles before the next one. The only case where nom_i sits outside the band is the zero-delta test, and there the band itself stays ordered.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef enum logic [1:0] {
    REQ_NONE = 2'b00,
    REQ_COMP = 2'b01,
    REQ_EXP  = 2'b10
  } agc_req_e;

  function automatic int unsigned curve_code(input int unsigned tbl, input int unsigned i,
                                             input int unsigned gain_w, input int unsigned idx_w);
    int unsigned sh;
    int unsigned v;
    sh = gain_w - idx_w;
    if (tbl % 2 == 0) v = (i << sh) + (1 << (sh - 1));
    else              v = i * i + i;
    return v % (1 << gain_w);
  endfunction
endpackage

// File: rtl/agc_tick_gen.sv
module agc_tick_gen #(
  parameter int unsigned TICK_DIV = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_x1_o,
  output logic tick_x2_o
);
  localparam int unsigned CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;
  logic             wrap;

  assign wrap = (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      phase_q   <= 1'b0;
      tick_x1_o <= 1'b0;
      tick_x2_o <= 1'b0;
    end else begin
      tick_x1_o <= wrap;
      tick_x2_o <= wrap & phase_q;
      if (wrap) begin
        cnt_q   <= '0;
        phase_q <= ~phase_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/agc_level_judge.sv
module agc_level_judge
  import agc_pkg::*;
#(
  parameter int unsigned LVL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_valid_i,
  input  logic [LVL_W-1:0] avg_i,
  input  logic [LVL_W-1:0] lo_thr_i,
  input  logic [LVL_W-1:0] hi_thr_i,
  input  logic [LVL_W-1:0] nom_i,
  output agc_req_e         req_o,
  output logic             delta_nz_o
);
  logic [LVL_W-1:0] delta_q;
  agc_req_e         req_d;
  logic [LVL_W-1:0] delta_d;

  always_comb begin
    // compress wins if a misordered band would flag both
    if (avg_i > hi_thr_i)      req_d = REQ_COMP;
    else if (avg_i < lo_thr_i) req_d = REQ_EXP;
    else                       req_d = REQ_NONE;
    delta_d = (avg_i >= nom_i) ? (avg_i - nom_i) : (nom_i - avg_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o   <= REQ_NONE;
      delta_q <= '0;
    end else if (set_valid_i) begin
      req_o   <= req_d;
      delta_q <= delta_d;
    end
  end

  assign delta_nz_o = |delta_q;
endmodule

// File: rtl/agc_gain_table.sv
module agc_gain_table
  import agc_pkg::*;
#(
  parameter int unsigned GAIN_W   = 8,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned N_TABLES = 2,
  parameter int unsigned SEL_W    = 1
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [GAIN_W-1:0] gain_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [GAIN_W-1:0] rom [N_TABLES][DEPTH];

  for (genvar t = 0; t < N_TABLES; t++) begin : g_tbl
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      assign rom[t][i] = GAIN_W'(curve_code(t, i, GAIN_W, IDX_W));
    end
  end

  logic [SEL_W-1:0] sel_c;
  always_comb begin
    if (int'(sel_i) >= N_TABLES) sel_c = SEL_W'(N_TABLES - 1);
    else                         sel_c = sel_i;
    gain_o = rom[sel_c][idx_i];
  end
endmodule

// File: rtl/agc_index_walker.sv
module agc_index_walker
  import agc_pkg::*;
#(
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned UNITY_IDX = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_x1_i,
  input  logic             tick_x2_i,
  input  agc_req_e         req_i,
  input  logic             delta_nz_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] IDX_MAX  = '1;
  localparam logic [IDX_W-1:0] IDX_INIT = IDX_W'(UNITY_IDX);

  logic do_down, do_up;

  always_comb begin
    do_down = tick_x1_i && (req_i == REQ_COMP) && delta_nz_i && (idx_o != '0);
    do_up   = tick_x2_i && (req_i == REQ_EXP)  && delta_nz_i && (idx_o != IDX_MAX);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_o <= IDX_INIT;
    else if (do_down) idx_o <= idx_o - 1'b1;
    else if (do_up)   idx_o <= idx_o + 1'b1;
  end
endmodule

// File: rtl/agc_step_ctrl.sv
module agc_step_ctrl
  import agc_pkg::*;
#(
  parameter int unsigned LVL_W     = 8,
  parameter int unsigned GAIN_W    = 8,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned N_TABLES  = 2,
  parameter int unsigned SEL_W     = (N_TABLES > 1) ? $clog2(N_TABLES) : 1,
  parameter int unsigned UNITY_IDX = 8,
  parameter int unsigned TICK_DIV  = 100000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_valid_i,
  input  logic [LVL_W-1:0]  avg_i,
  input  logic [LVL_W-1:0]  lo_thr_i,
  input  logic [LVL_W-1:0]  hi_thr_i,
  input  logic [LVL_W-1:0]  nom_i,
  input  logic [SEL_W-1:0]  tbl_sel_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic     tick_x1, tick_x2;
  agc_req_e req;
  logic     delta_nz;

  agc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i, .rst_ni, .tick_x1_o(tick_x1), .tick_x2_o(tick_x2)
  );

  agc_level_judge #(.LVL_W(LVL_W)) u_judge (
    .clk_i, .rst_ni, .set_valid_i, .avg_i, .lo_thr_i, .hi_thr_i, .nom_i,
    .req_o(req), .delta_nz_o(delta_nz)
  );

  agc_index_walker #(.IDX_W(IDX_W), .UNITY_IDX(UNITY_IDX)) u_walk (
    .clk_i, .rst_ni, .tick_x1_i(tick_x1), .tick_x2_i(tick_x2),
    .req_i(req), .delta_nz_i(delta_nz), .idx_o
  );

  agc_gain_table #(.GAIN_W(GAIN_W), .IDX_W(IDX_W), .N_TABLES(N_TABLES), .SEL_W(SEL_W)) u_tbl (
    .sel_i(tbl_sel_i), .idx_i(idx_o), .gain_o
  );
endmodule

// File: rtl/agc_step_ctrl_chk.sv
module agc_step_ctrl_chk #(
  parameter int unsigned IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             set_valid_i,
  input logic             tick_x1_i,
  input logic             tick_x2_i,
  input logic [1:0]       req_i,
  input logic [IDX_W-1:0] idx_i
);
  p_x2_on_x1_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_x2_i |-> tick_x1_i);

  p_req_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(req_i) <= 1);

  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_valid_i |=> $stable(req_i));

  p_down_on_x1_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_i < $past(idx_i)) |-> $past(tick_x1_i && req_i == 2'b01));

  p_up_on_x2_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_i > $past(idx_i)) |-> $past(tick_x2_i && req_i == 2'b10));

  p_one_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_i == $past(idx_i)) || (idx_i == $past(idx_i) + 1'b1) || (idx_i == $past(idx_i) - 1'b1));

  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == 2'b00) |=> $stable(idx_i));
endmodule

bind agc_step_ctrl agc_step_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .set_valid_i(set_valid_i),
  .tick_x1_i(tick_x1), .tick_x2_i(tick_x2), .req_i(req), .idx_i(idx_o)
);

// File: tb/agc_step_ctrl_test.sv
module agc_step_ctrl_test;
  localparam int DIV = 10;
  localparam int NV  = 9;
  localparam int VEC_AVG [NV] = '{200, 120, 40, 161, 160, 80, 79, 255, 0};
  localparam int VEC_DIR [NV] = '{ -1,   0, +1,  -1,   0,  0, +1,  -1, +1};

  logic       clk = 0;
  logic       rst_n = 0;
  logic       set_v = 0;
  logic [7:0] avg = 0, lo = 80, hi = 160, nom = 120;
  logic       sel = 0;
  logic [7:0] gain;
  logic [3:0] idx;

  int checks = 0, errors = 0, jumps = 0;
  bit done = 0;

  agc_step_ctrl #(.TICK_DIV(DIV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .set_valid_i(set_v), .avg_i(avg),
    .lo_thr_i(lo), .hi_thr_i(hi), .nom_i(nom), .tbl_sel_i(sel),
    .gain_o(gain), .idx_o(idx)
  );

  always #5 clk = ~clk;

  function automatic int lin(input int i); return i * 16 + 8; endfunction
  function automatic int quad(input int i); return i * i + i; endfunction

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic strobe(input int lvl);
    @(negedge clk); avg = 8'(lvl); set_v = 1;
    @(negedge clk); set_v = 0;
  endtask

  task automatic wait_change(output int cyc);
    logic [3:0] s;
    s = idx; cyc = 0;
    while (idx == s && cyc < 500) begin @(negedge clk); cyc++; end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R9: watch for any jump of more than one per cycle
  logic [3:0] prev_idx;
  always @(negedge clk) begin
    if (rst_n && prev_idx !== idx && (int'(idx) - int'(prev_idx) > 1 || int'(prev_idx) - int'(idx) > 1))
      jumps++;
    prev_idx <= idx;
  end

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c, d, s;
    idle(3);
    chk("R1 idx in reset", idx, 8);
    chk("R1 gain in reset", gain, lin(8));
    @(negedge clk); rst_n = 1;
    idle(30);
    chk("R1/R11 idx after reset idle", idx, 8);
    sel = 1; #1;
    chk("R10 table1 gain", gain, quad(8));
    sel = 0; #1;
    chk("R10 table0 gain", gain, lin(8));

    // R4 classification table
    for (int v = 0; v < NV; v++) begin
      s = idx;
      strobe(VEC_AVG[v]);
      idle(45);
      d = (idx > s) ? 1 : ((idx < s) ? -1 : 0);
      chk($sformatf("R4 direction avg=%0d", VEC_AVG[v]), d, VEC_DIR[v]);
    end

    // R11 in band, R5 avg change without strobe
    strobe(120);
    idle(5);
    s = idx;
    avg = 255;
    idle(60);
    chk("R5 no strobe no effect", idx, s);
    chk("R11 in band hold", idx, s);

    // R3 release interval
    strobe(0);
    wait_change(c);
    wait_change(c);
    chk("R3 release interval", c, 2 * DIV);
    c = 0;
    while (idx != 15 && c < 600) begin @(negedge clk); c++; end
    idle(60);
    chk("R7 ceiling idx", idx, 15);
    chk("R7 ceiling gain", gain, lin(15));

    // R8 zero delta
    nom = 200;
    strobe(200);
    idle(60);
    chk("R8 zero delta blocks", idx, 15);
    nom = 120;

    // R2 attack interval
    strobe(255);
    wait_change(c);
    wait_change(c);
    chk("R2 attack interval", c, DIV);
    c = 0;
    while (idx != 0 && c < 600) begin @(negedge clk); c++; end
    idle(40);
    chk("R6 floor idx", idx, 0);
    chk("R6 floor gain", gain, lin(0));
    sel = 1; #1;
    chk("R10 table1 floor gain", gain, quad(0));
    sel = 0;

    chk("R9 single steps", jumps, 0);

    // R1 reset again from floor
    @(negedge clk); rst_n = 0;
    idle(2);
    chk("R1 re-reset idx", idx, 8);
    @(negedge clk); rst_n = 1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    done = 1;
    $finish;
  end
endmodule